// File: doc/BRIEF.md
# Blocked LU Loop Index Generator

This block walks the three nested loops of a blocked LU factorisation of an N by N matrix and hands one index triple (row-step `i`, column-block base `k`, target row `j`) per accepted cycle to the address-generation and compute stages that follow it. The pivot index `i` runs over the whole order. For each pivot the block-base index `k` steps across the column blocks of width K, beginning at the block that contains the pivot column, so blocks that have already been eliminated are never visited. For each `(i, k)` pair the row index `j` runs from the pivot row to the last row.

The matrix order is given at run time on `n_order` and is captured when a run starts. The block width K is a build-time parameter. A one-cycle `start` launches a run. Triples come out on `idx_i`, `idx_k` and `idx_j`, qualified by `idx_valid`. A triple counts as accepted on a rising edge where both `idx_valid` and `ready` are high. When `ready` is low the whole register chain holds still. After the final triple is accepted, `done` pulses once and the block goes idle.

Top module: `lu_loop_idx_gen`

## Requirements
- R1: For every triple, `idx_i` lies in 1..N and `idx_j` lies in `idx_i`..N. Within one `(i, k)` pair, `j` increases by one from `i` to N.
- R2: For pivot `i`, the first `idx_k` is `((i-1)/K)*K` (integer division). `idx_k` then rises in steps of K. The last value is the largest multiple of K that does not exceed N+1-K, which is N-K.
- R3: Nesting is `i` outermost, then `k`, then `j` innermost. Exactly one triple is produced per accepted cycle. The accepted count equals the sum, over each `i`, of the number of `k` values times (N-i+1).
- R4: `n_order` (16, 32, 64 or 128) is sampled only when a run starts. Changing it during a run has no effect on that run's triples.
- R5: With `ready` high, the first triple (1, 0, 1) is presented with `idx_valid` high after the second rising edge that follows the edge sampling `start`. After the first and after the second-to-last of those edges, `idx_valid` is still low.
- R6: While `idx_valid` is high and `ready` is low, the outputs hold their values. No triple is skipped or duplicated across a stall.
- R7: `done` is high for exactly one cycle: the cycle after the final triple (N, N-K, N) is accepted. After that, `idx_valid` and `done` stay low until the next start.
- R8: A `start` pulse while a run is in progress is ignored, and the running sequence continues unchanged.
- R9: After synchronous active-low reset, `idx_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle run launch, ignored while busy |
| n_order | input | 8 | Matrix order N, sampled at start |
| ready | input | 1 | Downstream accepts the presented triple |
| idx_valid | output | 1 | Triple on the index outputs is valid |
| idx_i | output | 8 | Pivot index i |
| idx_k | output | 8 | Column block base k |
| idx_j | output | 8 | Row index j |
| done | output | 1 | One-cycle pulse after the final triple is accepted |

## Verification
Each run is checked triple by triple against a queue filled by plain nested loops written from R1 to R3. The runs cover every supported order from 16 to 128.

A run with `ready` held high separates correct loop bounds and the two-cycle latency from off-by-one errors in the `k` start or end. Runs with random `ready` stalls, drawn from `$urandom` with a fixed seed, separate a correct hold from a design that skips or repeats a triple when it advances under a stall. A directed stray `start`, sent together with a changed `n_order` partway through a run, separates a design that latches N and guards its start from one that restarts or rescales its bounds.

// File: rtl/lu_idx_pkg.sv
// Package: shared sizing and the triple record passed between the
// counter nest and the output register chain.
// Assumes the largest supported matrix order is 128.
package lu_idx_pkg;
    parameter int unsigned LU_NMAX = 128;
    localparam int unsigned LU_IW  = $clog2(LU_NMAX + 1);

    typedef logic [LU_IW-1:0] idx_t;

    typedef struct packed {
        logic vld;
        logic last;
        idx_t i;
        idx_t k;
        idx_t j;
    } triple_t;
endpackage

// File: rtl/lu_idx_bounds.sv
// Bounds arithmetic: the first column block for the pivot after the
// current one, and the last legal block base N-K.
// Assumes K is a power of two, so block alignment is a mask.
module lu_idx_bounds
    import lu_idx_pkg::*;
#(
    parameter int unsigned K = 8
) (
    input  idx_t i_cur,
    input  idx_t n_lat,
    output idx_t kfirst_nx,
    output idx_t klast
);
    localparam idx_t KMASK = idx_t'(K - 1);
    localparam idx_t KSTEP = idx_t'(K);

    // block base of pivot i_cur+1 is ((i_cur+1-1)/K)*K = i_cur with low bits cleared
    always_comb begin
        kfirst_nx = i_cur & ~KMASK;
        klast     = n_lat - KSTEP;
    end
endmodule

// File: rtl/lu_idx_counters.sv
// Counter nest: holds i, k, j and the latched order, and steps them in
// i / k / j nesting order on each advance.
// Assumes start_ok is never high while run is high, and that N is a
// multiple of K.
module lu_idx_counters
    import lu_idx_pkg::*;
#(
    parameter int unsigned K = 8
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start_ok,
    input  idx_t    n_in,
    input  logic    adv,
    output triple_t cur,
    output logic    run,
    output idx_t    n_held
);
    localparam int unsigned KB    = $clog2(K);
    localparam idx_t        KSTEP = idx_t'(K);
    localparam idx_t        KMASK = idx_t'(K - 1);

    idx_t i_q, k_q, j_q, n_q;
    idx_t kfirst_nx, klast;

    lu_idx_bounds #(.K(K)) bounds_i (
        .i_cur    (i_q),
        .n_lat    (n_q),
        .kfirst_nx(kfirst_nx),
        .klast    (klast)
    );

    // launch a run or step the innermost loop that still has room
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
            i_q <= '0;
            k_q <= '0;
            j_q <= '0;
            n_q <= '0;
        end else if (start_ok) begin
            run <= 1'b1;
            n_q <= n_in;
            i_q <= idx_t'(1);
            k_q <= '0;
            j_q <= idx_t'(1);
        end else if (run && adv) begin
            if (j_q != n_q) begin
                j_q <= j_q + idx_t'(1);
            end else if (k_q != klast) begin
                k_q <= k_q + KSTEP;
                j_q <= i_q;
            end else if (i_q != n_q) begin
                i_q <= i_q + idx_t'(1);
                k_q <= kfirst_nx;
                j_q <= i_q + idx_t'(1);
            end else begin
                run <= 1'b0;
            end
        end
    end

    // present the current state as a triple, flagging the final one
    always_comb begin
        cur.vld  = run;
        cur.last = (i_q == n_q) && (j_q == n_q) && (k_q == klast);
        cur.i    = i_q;
        cur.k    = k_q;
        cur.j    = j_q;
        n_held   = n_q;
    end

    AST_J_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (j_q >= i_q) && (j_q <= n_q) && (i_q != '0)); // R1
    AST_K_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (k_q[KB-1:0] == '0) && (k_q <= n_q - KSTEP)); // R2
    AST_K_FROM_PIVOT: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (k_q >= ((i_q - idx_t'(1)) & ~KMASK))); // R2
    AST_N_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> $stable(n_q)); // R4
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !adv) |=> ($stable(i_q) && $stable(k_q) && $stable(j_q))); // R6
endmodule

// File: rtl/lu_idx_pipe.sv
// Output register chain: two stages between the counters and the
// ports, all advancing together on adv.
// Assumes the caller stalls the counters with the same adv.
module lu_idx_pipe
    import lu_idx_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    adv,
    input  triple_t cur,
    output triple_t s1,
    output triple_t outq
);
    // shift both stages when the consumer takes the output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1   <= '0;
            outq <= '0;
        end else if (adv) begin
            s1   <= cur;
            outq <= s1;
        end
    end

    AST_STALL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (outq.vld && !adv) |=> $stable(outq)); // R6
endmodule

// File: rtl/lu_loop_idx_gen.sv
// Top: blocked LU loop index generator. Guards start while busy,
// chains counters and output registers, and pulses done after the
// final triple is accepted.
// Assumes n_order is one of 16, 32, 64, 128 at start, and K is 4, 8 or 16.
module lu_loop_idx_gen
    import lu_idx_pkg::*;
#(
    parameter int unsigned K = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LU_IW-1:0] n_order,
    input  logic             ready,
    output logic             idx_valid,
    output logic [LU_IW-1:0] idx_i,
    output logic [LU_IW-1:0] idx_k,
    output logic [LU_IW-1:0] idx_j,
    output logic             done
);
    generate
        if ((K & (K - 1)) != 0 || K < 2 || K > LU_NMAX) begin : g_bad_k
            $error("lu_loop_idx_gen: K must be a power of two within the order range");
        end
    endgenerate

    triple_t cur, s1, outq;
    logic    run, busy, start_ok, done_q;
    idx_t    n_held;

    // busy while any stage still carries part of a run
    always_comb begin
        busy     = run | s1.vld | outq.vld;
        start_ok = start & ~busy;
    end

    lu_idx_counters #(.K(K)) cnt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_ok(start_ok),
        .n_in    (n_order),
        .adv     (ready),
        .cur     (cur),
        .run     (run),
        .n_held  (n_held)
    );

    lu_idx_pipe pipe_i (
        .clk  (clk),
        .rst_n(rst_n),
        .adv  (ready),
        .cur  (cur),
        .s1   (s1),
        .outq (outq)
    );

    // one-cycle done after the consumer takes the final triple
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= outq.vld & outq.last & ready;
    end

    // drive the ports from the last stage
    always_comb begin
        idx_valid = outq.vld;
        idx_i     = outq.i;
        idx_k     = outq.k;
        idx_j     = outq.j;
        done      = done_q;
    end

    AST_DONE_AFTER_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(idx_valid && ready && (idx_i == n_held) && (idx_j == n_held))); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_START_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (start && run && !ready) |=> ($stable(idx_i) && $stable(idx_j))); // R8
endmodule

// File: tb/lu_loop_idx_gen_tb_top.sv
module lu_loop_idx_gen_tb_top;
    localparam int TB_K  = 8;
    localparam int WD_CY = 180000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       start;
    logic [7:0] n_order;
    logic       ready;
    logic       idx_valid;
    logic [7:0] idx_i, idx_k, idx_j;
    logic       done;

    int tests = 0;
    int fails = 0;
    int exp_q[$];

    always #4 clk = ~clk;

    lu_loop_idx_gen #(.K(TB_K)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .n_order(n_order),
        .ready(ready), .idx_valid(idx_valid), .idx_i(idx_i),
        .idx_k(idx_k), .idx_j(idx_j), .done(done)
    );

    function automatic int pack3(int i, int k, int j);
        return (i << 16) | (k << 8) | j;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // expected triples straight from the nested loop definition (R1 R2 R3)
    task automatic build(int n);
        exp_q.delete();
        for (int i = 1; i <= n; i++)
            for (int k = ((i - 1) / TB_K) * TB_K; k <= n + 1 - TB_K; k += TB_K)
                for (int j = i; j <= n; j++)
                    exp_q.push_back(pack3(i, k, j));
    endtask

    task automatic run_case(int n, int stall_pct, bit poke);
        int  total;
        int  acc;
        int  cyc;
        int  held;
        bit  stalled;
        bit  last_acc;
        int  got;
        build(n);
        total    = exp_q.size();
        acc      = 0;
        cyc      = 0;
        stalled  = 0;
        last_acc = 0;
        held     = 0;
        @(negedge clk);
        n_order = 8'(n);
        ready   = 1'b1;
        start   = 1'b1;
        forever begin
            @(posedge clk);
            @(negedge clk);
            start = 1'b0;
            if (poke && cyc == 40) begin
                start   = 1'b1;                                    // R8 stray start
                n_order = (n == 128) ? 8'd16 : 8'd128;             // R4 changed order
            end
            if (last_acc) begin
                chk(done == 1'b1, "R7", "done after final", done, 1);
                break;
            end
            chk(done == 1'b0, "R7", "no early done", done, 0);
            got = pack3(idx_i, idx_k, idx_j);
            if (cyc < 2) chk(idx_valid == 1'b0, "R5", "valid before latency", idx_valid, 0);
            if (cyc == 2) chk(idx_valid && got == pack3(1, 0, 1), "R5", "first triple",
                              idx_valid ? got : -1, pack3(1, 0, 1));
            if (stalled) chk(idx_valid && got == held, "R6", "held across stall", got, held);
            ready = (cyc < 3) ? 1'b1 : (int'($urandom_range(99)) >= stall_pct);
            stalled = idx_valid && !ready;
            held    = got;
            if (idx_valid && ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3", "extra triple", got, 0);
                end else begin
                    chk(got == exp_q[0], "R1 R2 R3", "triple order", got, exp_q[0]);
                    void'(exp_q.pop_front());
                    acc++;
                    last_acc = (exp_q.size() == 0);
                end
            end
            cyc++;
        end
        ready = 1'b1;
        chk(acc == total, "R3", "accepted count", acc, total);
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            chk(!idx_valid && !done, "R7", "idle after done", {idx_valid, done}, 0);
        end
    endtask

    initial begin
        repeat (WD_CY) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", WD_CY);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int nsel;
        void'($urandom(32'd2024));
        rst_n   = 1'b0;
        start   = 1'b0;
        ready   = 1'b0;
        n_order = 8'd16;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!idx_valid && !done, "R9", "reset state", {idx_valid, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!idx_valid && !done, "R9", "after reset release", {idx_valid, done}, 0);

        run_case(16, 0, 1'b0);
        run_case(16, 30, 1'b1);
        run_case(32, 40, 1'b0);
        nsel = ($urandom_range(1) == 0) ? 16 : 32;
        run_case(nsel, int'($urandom_range(60)), 1'b1);
        run_case(64, 20, 1'b1);
        run_case(128, 0, 1'b0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule